// File: doc/BRIEF.md
# Parallel FPGA Configuration Stream Loader

This block takes a configuration bitstream as a byte stream on a valid/ready interface and plays it into the byte-wide parallel configuration port of a target FPGA. The port side has a program output, an active-low chip select, a write enable, a configuration clock and eight data pins. It reads back the device's init and done status pins. Both status inputs pass through a synchroniser before use.

After a start request the loader hunts for a run of four 0xFF bytes within a bounded window. Once it finds them it resets the device: a program pulse, then a wait for init, then write, then select. It then clocks out the four header bytes and every later byte, each one bit-reversed. An end request moves the bus through an ordered release. The loader then samples done and reports pass or fail together with the number of bytes it wrote. A missing header, an init pin that never rises, and a stream abandoned while hunting each end the load with their own status flag.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset the block is idle: busy low, in_ready low, program output high, chip select high (deselected), write low, configuration clock low, all status flags low and the byte count zero.
- R2: While hunting, a 0xFF byte adds one to a run count and any other byte clears it. The header is found when the run reaches four. Bytes consumed before the header are never sent to the device.
- R3: Every byte consumed while hunting counts toward a window of SEARCH_MAX bytes (default 256). If byte number SEARCH_MAX completes the header, the load goes on. Otherwise that byte ends the load with sync_error, and the program output never goes low.
- R4: After the header is found, the device receives four 0xFF bytes first. It then receives every later input byte, in input order.
- R5: Each byte sent is bit-reversed: input bit i drives configuration data pin 7-i.
- R6: Start order: the program output is low for exactly PHASE_CYC cycles while chip select is high and write is low. It then stays high for at least PHASE_CYC cycles before write rises. Write rises only after init has been seen high. Chip select falls only while write is high.
- R7: Each byte uses three clock phases of PHASE_CYC cycles: clock low, clock high, clock low. Data is stable from the rising edge to the falling edge. The clock toggles only while chip select is low and write is high.
- R8: Stop order: chip select rises while write and program are high and the clock is low. Write falls at least PHASE_CYC cycles later, and never while chip select is low.
- R9: At the end of the stop sequence the synchronised done input is sampled. If it is high, done_ok is set; if it is low, done_fail is set. byte_count equals the number of bytes clocked into the device, header included. At most one status flag is high at a time.
- R10: If init stays low for INIT_TIMEOUT cycles after the program pulse, the block sets init_timeout and goes idle. Write is never raised and chip select is never lowered during that load.
- R11: A start request while busy is ignored and the load in progress continues unchanged. A start request while idle clears all status flags and the byte count.
- R12: An end request while hunting ends the load with sync_error, and the program output never goes low. A byte offered in the same cycle is discarded.
- R13: in_ready is high only while hunting, or between device bytes once the header bytes are out and no end request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (pulse); ignored while busy |
| end_i | input | 1 | End-of-stream request (pulse) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| cfg_prog_o | output | 1 | Device program output; low pulse resets the device |
| cfg_cs_n_o | output | 1 | Device chip select, active low |
| cfg_write_o | output | 1 | Device write enable, active high |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data pins (bit-reversed byte) |
| cfg_init_i | input | 1 | Device init status, asynchronous |
| cfg_done_i | input | 1 | Device done status, asynchronous |
| busy_o | output | 1 | A load is in progress |
| sync_error_o | output | 1 | Header not found, or stream ended while hunting |
| init_timeout_o | output | 1 | Init never rose after the program pulse |
| done_ok_o | output | 1 | Load finished with done high |
| done_fail_o | output | 1 | Load finished with done low |
| byte_count_o | output | 32 | Bytes clocked into the device during the last load |

## Verification
The bench targets these corner cases:
- A header preceded by a broken 0xFF run. A design that did not clear the run count would lock on too early and send junk.
- A five-byte 0xFF run, where the fifth byte must go out as data rather than be swallowed.
- A header finishing on exactly the last byte of the window, next to a stream with no header at all. An off-by-one window would either reject the first or read one byte too many from the second.
- An init pin that never rises. A start request issued in the middle of a hunt, which a careless design would let restart the hunt. An end request during the hunt.
- On every clock, a target-side monitor checks the pin ordering and phase lengths against fixed bounds. Any swapped release order or a short phase is reported when it happens.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   localparam int          BYTE_W    = 8;
   localparam int          HDR_LEN   = 4;
   localparam logic [7:0]  SYNC_BYTE = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HUNT,
      ST_RST_LO,
      ST_RST_HI,
      ST_WAIT_INIT,
      ST_ARM,
      ST_SELECT,
      ST_FETCH,
      ST_CLK_LO1,
      ST_CLK_HI,
      ST_CLK_LO2,
      ST_REL_CS,
      ST_REL_WR
   } ld_state_e;

   typedef struct packed {
      logic prog;
      logic cs_n;
      logic wr;
      logic cclk;
   } port_pins_t;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("cfgld_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic sh [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
            end
         end
      end
      assign q = sh[STAGES-1];
   end

endmodule

// File: rtl/cfgld_bitrev.sv
module cfgld_bitrev #(
   parameter int W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (W < 1) begin : g_bad_w
      $error("cfgld_bitrev: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_swap
      assign dout[i] = din[W-1-i];
   end

endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign expired = (cnt_q == '0);

   AST_TMR_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired); // R7

endmodule

// File: rtl/cfgld_hunt.sv
module cfgld_hunt
   import cfgld_pkg::*;
#(
   parameter int SEARCH_MAX = 256,
   parameter int RUN_LEN    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              found,
   output logic              exhausted
);

   localparam int SW = $clog2(SEARCH_MAX + 1);
   localparam int RW = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 1 || SEARCH_MAX < RUN_LEN) begin : g_bad_cfg
      $error("cfgld_hunt: need 1 <= RUN_LEN <= SEARCH_MAX");
   end

   logic [RW-1:0] run_q;
   logic [SW-1:0] seen_q;
   logic          is_sync;

   assign is_sync   = (byte_i == SYNC_BYTE);
   assign found     = take && is_sync && (run_q == RW'(RUN_LEN - 1));
   assign exhausted = take && !found && (seen_q == SW'(SEARCH_MAX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         seen_q <= '0;
      end else if (clear) begin
         run_q  <= '0;
         seen_q <= '0;
      end else if (take) begin
         run_q  <= is_sync ? run_q + RW'(1) : '0;
         seen_q <= seen_q + SW'(1);
      end
   end

   AST_HUNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({found, exhausted})); // R3

   AST_HUNT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q <= SW'(SEARCH_MAX)); // R3

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
   import cfgld_pkg::*;
#(
   parameter int PHASE_CYC    = 15,
   parameter int INIT_TIMEOUT = 50000,
   parameter int SEARCH_MAX   = 256,
   parameter int SYNC_STAGES  = 2,
   parameter int CNT_W        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              end_i,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              cfg_prog_o,
   output logic              cfg_cs_n_o,
   output logic              cfg_write_o,
   output logic              cfg_cclk_o,
   output logic [BYTE_W-1:0] cfg_data_o,
   input  logic              cfg_init_i,
   input  logic              cfg_done_i,
   output logic              busy_o,
   output logic              sync_error_o,
   output logic              init_timeout_o,
   output logic              done_ok_o,
   output logic              done_fail_o,
   output logic [CNT_W-1:0]  byte_count_o
);

   localparam int TMAX = (PHASE_CYC > INIT_TIMEOUT) ? PHASE_CYC : INIT_TIMEOUT;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int HW   = $clog2(HDR_LEN + 1);

   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("cfg_stream_loader: PHASE_CYC must be at least 1");
   end
   if (INIT_TIMEOUT < 1) begin : g_bad_tout
      $error("cfg_stream_loader: INIT_TIMEOUT must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("cfg_stream_loader: CNT_W must be at least 1");
   end

   // ---------------------------------------------------------------
   // Status pin synchronisers
   // ---------------------------------------------------------------
   logic init_s, done_s;

   cfgld_sync #(.STAGES(SYNC_STAGES)) i_sync_init (
      .clk(clk), .rst_n(rst_n), .d(cfg_init_i), .q(init_s));
   cfgld_sync #(.STAGES(SYNC_STAGES)) i_sync_done (
      .clk(clk), .rst_n(rst_n), .d(cfg_done_i), .q(done_s));

   // ---------------------------------------------------------------
   // State
   // ---------------------------------------------------------------
   ld_state_e        st_q, st_d;
   logic [HW-1:0]    hdr_left_q;
   logic             end_q;
   logic [BYTE_W-1:0] data_q;
   logic [CNT_W-1:0] count_q;
   logic             serr_q, tout_q, ok_q, fail_q;
   port_pins_t       pins_q;

   logic take, found, exhausted;
   logic fetch_hdr, fetch_in, set_serr, set_tout, finish, start_ok;
   logic tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;
   logic [BYTE_W-1:0] byte_sel, byte_rev;

   assign start_ok = (st_q == ST_IDLE) && start_i;

   cfgld_hunt #(.SEARCH_MAX(SEARCH_MAX), .RUN_LEN(HDR_LEN)) i_hunt (
      .clk(clk), .rst_n(rst_n), .clear(start_ok), .take(take),
      .byte_i(in_data), .found(found), .exhausted(exhausted));

   cfgld_timer #(.W(TW)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_exp));

   assign byte_sel = fetch_hdr ? SYNC_BYTE : in_data;

   cfgld_bitrev #(.W(BYTE_W)) i_rev (.din(byte_sel), .dout(byte_rev));

   // ---------------------------------------------------------------
   // Next-state logic
   // ---------------------------------------------------------------
   always_comb begin
      st_d      = st_q;
      take      = 1'b0;
      fetch_hdr = 1'b0;
      fetch_in  = 1'b0;
      set_serr  = 1'b0;
      set_tout  = 1'b0;
      finish    = 1'b0;
      case (st_q)
         ST_IDLE:      if (start_i) st_d = ST_HUNT;
         ST_HUNT: begin
            if (end_i) begin
               st_d     = ST_IDLE;
               set_serr = 1'b1;
            end else if (in_valid) begin
               take = 1'b1;
               if (found) begin
                  st_d = ST_RST_LO;
               end else if (exhausted) begin
                  st_d     = ST_IDLE;
                  set_serr = 1'b1;
               end
            end
         end
         ST_RST_LO:    if (tmr_exp) st_d = ST_RST_HI;
         ST_RST_HI:    if (tmr_exp) st_d = ST_WAIT_INIT;
         ST_WAIT_INIT: begin
            if (init_s) begin
               st_d = ST_ARM;
            end else if (tmr_exp) begin
               st_d     = ST_IDLE;
               set_tout = 1'b1;
            end
         end
         ST_ARM:       st_d = ST_SELECT;
         ST_SELECT:    st_d = ST_FETCH;
         ST_FETCH: begin
            if (hdr_left_q != '0) begin
               fetch_hdr = 1'b1;
               st_d      = ST_CLK_LO1;
            end else if (end_q) begin
               st_d = ST_REL_CS;
            end else if (in_valid) begin
               fetch_in = 1'b1;
               st_d     = ST_CLK_LO1;
            end
         end
         ST_CLK_LO1:   if (tmr_exp) st_d = ST_CLK_HI;
         ST_CLK_HI:    if (tmr_exp) st_d = ST_CLK_LO2;
         ST_CLK_LO2:   if (tmr_exp) st_d = ST_FETCH;
         ST_REL_CS:    if (tmr_exp) st_d = ST_REL_WR;
         ST_REL_WR: begin
            if (tmr_exp) begin
               st_d   = ST_IDLE;
               finish = 1'b1;
            end
         end
         default:      st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      tmr_val  = TW'(PHASE_CYC - 1);
      tmr_load = 1'b0;
      if (st_d != st_q) begin
         case (st_d)
            ST_RST_LO, ST_RST_HI, ST_CLK_LO1, ST_CLK_HI, ST_CLK_LO2,
            ST_REL_CS, ST_REL_WR: tmr_load = 1'b1;
            ST_WAIT_INIT: begin
               tmr_load = 1'b1;
               tmr_val  = TW'(INIT_TIMEOUT - 1);
            end
            default: tmr_load = 1'b0;
         endcase
      end
   end

   function automatic port_pins_t pins_for(ld_state_e s);
      port_pins_t p;
      p = '{prog: 1'b1, cs_n: 1'b1, wr: 1'b0, cclk: 1'b0};
      case (s)
         ST_RST_LO:  p.prog = 1'b0;
         ST_ARM:     p.wr   = 1'b1;
         ST_SELECT, ST_FETCH, ST_CLK_LO1, ST_CLK_LO2: begin
            p.wr   = 1'b1;
            p.cs_n = 1'b0;
         end
         ST_CLK_HI: begin
            p.wr   = 1'b1;
            p.cs_n = 1'b0;
            p.cclk = 1'b1;
         end
         ST_REL_CS:  p.wr = 1'b1;
         default:    p.wr = 1'b0;
      endcase
      return p;
   endfunction

   // ---------------------------------------------------------------
   // Registers
   // ---------------------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         hdr_left_q <= '0;
         end_q      <= 1'b0;
         data_q     <= '0;
         count_q    <= '0;
         serr_q     <= 1'b0;
         tout_q     <= 1'b0;
         ok_q       <= 1'b0;
         fail_q     <= 1'b0;
         pins_q     <= pins_for(ST_IDLE);
      end else begin
         st_q   <= st_d;
         pins_q <= pins_for(st_d);
         if (start_ok) begin
            hdr_left_q <= '0;
            end_q      <= 1'b0;
            count_q    <= '0;
            serr_q     <= 1'b0;
            tout_q     <= 1'b0;
            ok_q       <= 1'b0;
            fail_q     <= 1'b0;
         end
         if (st_q != ST_IDLE && st_q != ST_HUNT && end_i) end_q <= 1'b1;
         if (st_q == ST_HUNT && st_d == ST_RST_LO) hdr_left_q <= HW'(HDR_LEN);
         if (fetch_hdr) hdr_left_q <= hdr_left_q - HW'(1);
         if (fetch_hdr || fetch_in) begin
            data_q  <= byte_rev;
            count_q <= count_q + CNT_W'(1);
         end
         if (set_serr) serr_q <= 1'b1;
         if (set_tout) tout_q <= 1'b1;
         if (finish) begin
            ok_q   <= done_s;
            fail_q <= !done_s;
         end
      end
   end

   assign in_ready       = (st_q == ST_HUNT) ||
                           (st_q == ST_FETCH && hdr_left_q == '0 && !end_q);
   assign busy_o         = (st_q != ST_IDLE);
   assign cfg_prog_o     = pins_q.prog;
   assign cfg_cs_n_o     = pins_q.cs_n;
   assign cfg_write_o    = pins_q.wr;
   assign cfg_cclk_o     = pins_q.cclk;
   assign cfg_data_o     = data_q;
   assign sync_error_o   = serr_q;
   assign init_timeout_o = tout_q;
   assign done_ok_o      = ok_q;
   assign done_fail_o    = fail_q;
   assign byte_count_o   = count_q;

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   AST_PROG_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_prog_o |-> (cfg_cs_n_o && !cfg_write_o)); // R6

   AST_SELECT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cs_n_o |-> (cfg_write_o && cfg_prog_o)); // R6

   AST_CCLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_cclk_o |-> !cfg_cs_n_o); // R7

   AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_cclk_o) |-> $stable(cfg_data_o)); // R7

   AST_DATA_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_cclk_o) |-> $stable(cfg_data_o)); // R7

   AST_CS_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_cs_n_o) |-> (!cfg_cclk_o && cfg_write_o && cfg_prog_o)); // R8

   AST_WRITE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_write_o) |-> (cfg_cs_n_o && $past(cfg_cs_n_o))); // R8

   AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sync_error_o, init_timeout_o, done_ok_o, done_fail_o})); // R9

   AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy_o); // R13

endmodule

// File: tb/test_cfg_stream_loader.sv
module test_cfg_stream_loader;

   localparam int P    = 3;
   localparam int TOUT = 40;

   typedef logic [7:0] byte_q_t[$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, end_i = 1'b0, in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_ready;
   logic cfg_prog_o, cfg_cs_n_o, cfg_write_o, cfg_cclk_o;
   logic [7:0] cfg_data_o;
   logic init_pin = 1'b1;
   logic done_pin = 1'b1;
   logic busy_o, sync_error_o, init_timeout_o, done_ok_o, done_fail_o;
   logic [31:0] byte_count_o;

   cfg_stream_loader #(.PHASE_CYC(P), .INIT_TIMEOUT(TOUT), .SEARCH_MAX(256),
                       .SYNC_STAGES(2), .CNT_W(32)) i_cfg_stream_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_i(end_i),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .cfg_prog_o(cfg_prog_o), .cfg_cs_n_o(cfg_cs_n_o),
      .cfg_write_o(cfg_write_o), .cfg_cclk_o(cfg_cclk_o),
      .cfg_data_o(cfg_data_o), .cfg_init_i(init_pin), .cfg_done_i(done_pin),
      .busy_o(busy_o), .sync_error_o(sync_error_o),
      .init_timeout_o(init_timeout_o), .done_ok_o(done_ok_o),
      .done_fail_o(done_fail_o), .byte_count_o(byte_count_o));

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // ---------------------------------------------------------------
   // Target-side model and pin monitor, run every cycle
   // ---------------------------------------------------------------
   logic [7:0] got[$];
   int  init_delay = 5;
   int  init_cnt = 0;
   bit  prog_fell_seen = 0, write_rose_seen = 0, cs_fell_seen = 0;
   logic p_prog = 1, p_cs_n = 1, p_wr = 0, p_cclk = 0;
   logic [7:0] hold_data = 8'h00;
   int  hi_len = 0, lo_len = 0, prog_lo = 0;
   int  since_prog_rise = 0, since_cs_rise = 0;
   bit  had_fall = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         since_prog_rise++;
         since_cs_rise++;
         // init pin: low from program pulse until init_delay cycles after it ends
         if (!cfg_prog_o) begin
            init_pin = 1'b0;
            init_cnt = 0;
         end else if (!init_pin) begin
            init_cnt++;
            if (init_delay >= 0 && init_cnt >= init_delay) init_pin = 1'b1;
         end
         // program pulse
         if (!cfg_prog_o && p_prog) begin
            prog_fell_seen = 1;
            prog_lo = 1;
         end else if (!cfg_prog_o) begin
            prog_lo++;
         end
         if (cfg_prog_o && !p_prog) begin
            chk(prog_lo == P, "R6", "program low length", prog_lo, P);
            since_prog_rise = 0;
         end
         // write / select ordering on entry
         if (cfg_write_o && !p_wr) begin
            write_rose_seen = 1;
            chk(since_prog_rise >= P, "R6", "program high before write",
                since_prog_rise, P);
            chk(init_pin == 1'b1, "R6", "init high before write", init_pin, 1);
         end
         if (!cfg_cs_n_o && p_cs_n) begin
            cs_fell_seen = 1;
            chk(cfg_write_o == 1'b1, "R6", "write high at select", cfg_write_o, 1);
            had_fall = 0;
         end
         // byte clocking
         if (cfg_cclk_o && !p_cclk) begin
            got.push_back(cfg_data_o);
            hold_data = cfg_data_o;
            hi_len = 1;
            chk(!cfg_cs_n_o && cfg_write_o, "R7", "clock while selected",
                {cfg_cs_n_o, cfg_write_o}, 2'b01);
            if (had_fall)
               chk(lo_len >= 2 * P + 1, "R7", "low time between bytes", lo_len, 2 * P + 1);
         end else if (cfg_cclk_o) begin
            hi_len++;
         end
         if (!cfg_cclk_o && p_cclk) begin
            chk(hi_len == P, "R7", "clock high length", hi_len, P);
            chk(cfg_data_o == hold_data, "R7", "data stable over byte",
                cfg_data_o, hold_data);
            lo_len = 1;
            had_fall = 1;
         end else if (!cfg_cclk_o) begin
            lo_len++;
         end
         // release ordering on exit
         if (cfg_cs_n_o && !p_cs_n) begin
            chk(!cfg_cclk_o && cfg_write_o && cfg_prog_o, "R8", "pins at deselect",
                {cfg_cclk_o, cfg_write_o, cfg_prog_o}, 3'b011);
            since_cs_rise = 0;
         end
         if (!cfg_write_o && p_wr) begin
            chk(cfg_cs_n_o && since_cs_rise >= P, "R8", "write release after select",
                since_cs_rise, P);
         end
      end
      p_prog = cfg_prog_o;
      p_cs_n = cfg_cs_n_o;
      p_wr   = cfg_write_o;
      p_cclk = cfg_cclk_o;
   end

   // ---------------------------------------------------------------
   // Reference: expected device bytes from an input stream
   // ---------------------------------------------------------------
   function automatic logic [7:0] rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7 - i];
      return r;
   endfunction

   function automatic void expect_stream(input byte_q_t s, output byte_q_t exp,
                                         output bit err, output int used);
      int run = 0;
      bit found = 0;
      exp = {};
      err = 0;
      used = 0;
      foreach (s[k]) begin
         if (!found) begin
            used++;
            if (s[k] == 8'hFF) run++;
            else run = 0;
            if (run == 4) begin
               found = 1;
               for (int j = 0; j < 4; j++) exp.push_back(8'hFF);
            end else if (used == 256) begin
               err = 1;
               break;
            end
         end else begin
            used++;
            exp.push_back(rev8(s[k]));
         end
      end
   endfunction

   // ---------------------------------------------------------------
   // Drivers
   // ---------------------------------------------------------------
   int consumed = 0;

   task automatic do_start();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      while (!in_ready && busy_o) @(negedge clk);
      if (in_ready) begin
         consumed++;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic end_and_wait();
      @(negedge clk);
      end_i = 1'b1;
      @(negedge clk);
      end_i = 1'b0;
      while (busy_o) @(negedge clk);
   endtask

   task automatic fresh();
      got = {};
      consumed = 0;
      prog_fell_seen = 0;
      write_rose_seen = 0;
      cs_fell_seen = 0;
   endtask

   task automatic compare(input byte_q_t s, input bit want_ok);
      byte_q_t exp;
      bit err;
      int used;
      expect_stream(s, exp, err, used);
      chk(consumed == used, "R3", "bytes consumed", consumed, used);
      chk(got.size() == exp.size(), "R4", "device byte count", got.size(), exp.size());
      for (int k = 0; k < exp.size() && k < got.size(); k++)
         chk(got[k] == exp[k], (k < 4) ? "R4" : "R5", "device byte", got[k], exp[k]);
      chk(sync_error_o == err, "R3", "sync_error", sync_error_o, err);
      if (!err) begin
         chk(byte_count_o == exp.size(), "R9", "byte_count", byte_count_o, exp.size());
         chk(done_ok_o == want_ok && done_fail_o == !want_ok, "R9", "done result",
             {done_ok_o, done_fail_o}, {want_ok, !want_ok});
      end
      chk(busy_o == 1'b0, "R9", "idle after load", busy_o, 0);
   endtask

   task automatic load(input byte_q_t s, input bit want_ok);
      fresh();
      done_pin = want_ok;
      do_start();
      chk(!sync_error_o && !init_timeout_o && !done_ok_o && !done_fail_o &&
          byte_count_o == 0, "R11", "status cleared by start",
          {sync_error_o, init_timeout_o, done_ok_o, done_fail_o}, 0);
      foreach (s[k]) push(s[k]);
      if (busy_o) end_and_wait();
      compare(s, want_ok);
   endtask

   // ---------------------------------------------------------------
   // Tests
   // ---------------------------------------------------------------
   initial begin
      byte_q_t s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: idle levels after reset, R13: not ready while idle
      chk(!busy_o && cfg_prog_o && cfg_cs_n_o && !cfg_write_o && !cfg_cclk_o,
          "R1", "idle pins", {busy_o, cfg_prog_o, cfg_cs_n_o, cfg_write_o, cfg_cclk_o},
          5'b01100);
      chk(!sync_error_o && !init_timeout_o && !done_ok_o && !done_fail_o &&
          byte_count_o == 0, "R1", "idle status", byte_count_o, 0);
      chk(in_ready == 1'b0, "R13", "in_ready while idle", in_ready, 0);

      // R2 R4 R5: broken run before the header, non-symmetric data
      s = '{8'h00, 8'hFF, 8'hFF, 8'h12, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
            8'h12, 8'hC1, 8'h01, 8'h2B};
      load(s, 1'b1);

      // R2 R9: five-byte 0xFF run, fifth goes out as data; done low -> fail
      s = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h0F};
      load(s, 1'b0);

      // R3: no header within the window
      s = {};
      for (int k = 0; k < 300; k++) s.push_back(8'h55);
      load(s, 1'b1);
      chk(prog_fell_seen == 0, "R3", "no program pulse on sync error", prog_fell_seen, 0);

      // R3 boundary: header completed by byte 256
      s = {};
      for (int k = 0; k < 252; k++) s.push_back(8'h00);
      for (int k = 0; k < 4; k++) s.push_back(8'hFF);
      load(s, 1'b1);

      // R10: init never rises
      init_delay = -1;
      fresh();
      do_start();
      push(8'hFF); push(8'hFF); push(8'hFF); push(8'hFF); push(8'h11);
      while (busy_o) @(negedge clk);
      chk(init_timeout_o == 1'b1, "R10", "init_timeout", init_timeout_o, 1);
      chk(!write_rose_seen && !cs_fell_seen, "R10", "bus untouched",
          {write_rose_seen, cs_fell_seen}, 0);
      chk(got.size() == 0, "R10", "no bytes clocked", got.size(), 0);
      init_delay = 5;

      // R11: start during hunt is ignored
      fresh();
      done_pin = 1'b1;
      do_start();
      chk(init_timeout_o == 1'b0, "R11", "timeout cleared by start", init_timeout_o, 0);
      push(8'hFF); push(8'hFF);
      do_start();
      push(8'hFF); push(8'hFF); push(8'h12);
      if (busy_o) end_and_wait();
      chk(got.size() == 5, "R11", "device bytes after ignored start", got.size(), 5);
      if (got.size() == 5)
         chk(got[4] == 8'h48, "R11", "data byte after ignored start", got[4], 8'h48);
      chk(done_ok_o == 1'b1, "R11", "load completed", done_ok_o, 1);

      // R12: end request during the hunt
      fresh();
      do_start();
      push(8'h00); push(8'hFF);
      end_and_wait();
      chk(sync_error_o == 1'b1, "R12", "sync_error on end while hunting", sync_error_o, 1);
      chk(prog_fell_seen == 0 && got.size() == 0, "R12", "device untouched",
          {prog_fell_seen, got.size() != 0}, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule